// File: doc/BRIEF.md
# Power-Down Clock Sequencer

This block orders a chip's entry into and exit from its deepest low-power state. A single asynchronous, active-low power-down request drives it. On entry, every controlled clock group is first gated low and held there. Only after each group confirms closure does the sequencer drop the oscillator and VCO enables. On exit it raises those enables again and waits out a settling time, counted on an always-on slow clock. It then reopens the gates. Every gate changes only while its clock is low, so no output pulse is ever cut short or stretched.

Each clock group has its own source clock and its own active-low stop request. The stop requests act only in normal operation. While power-down is active the sequencer holds every gate closed, whatever the stop inputs do. The power-down request is synchronised separately into each group's domain, which keeps entry latency short even though the sequencer runs on a slow clock. If the request returns during the settling wait, the sequencer goes straight back to the off state, and the next wake-up counts the full settling time again.

Top module: `pwrdn_clk_seq`

## Requirements
- R1: While rst_ni is low, osc_en_o and vco_en_o are 1 and every bit of gate_en_o and clk_o is 0. After reset is released with pd_ni high, the gates stay closed for at least SETTLE_CYCLES aon_clk_i cycles and then all open.
- R2: After pd_ni falls, gate_en_o[g] is 0 before the third rising edge of grp_clk_i[g]. The path is two synchroniser stages in that domain plus an enable register clocked on the falling edge.
- R3: osc_en_o and vco_en_o fall only after every gate_en_o bit is 0. Both stay 0 while pd_ni stays low.
- R4: While power-down is active, stop_ni has no effect: clk_o and gate_en_o stay 0 whatever stop_ni does.
- R5: When pd_ni rises after a completed power-down, osc_en_o and vco_en_o are 1 within four aon_clk_i cycles. The gates stay closed until SETTLE_CYCLES aon_clk_i cycles have elapsed with the enables high.
- R6: If pd_ni falls again during the settling wait, osc_en_o and vco_en_o return to 0 with all gates closed. The following wake-up waits the full SETTLE_CYCLES again.
- R7: In normal operation, stop_ni[g] at 0 closes only gate g, within three rising edges of grp_clk_i[g]. Returning it to 1 reopens gate g within the same bound.
- R8: Every high pulse on clk_o[g] lasts exactly half a period of grp_clk_i[g]. No low pulse is shorter than half a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aon_clk_i | input | 1 | Always-on slow clock for the sequencer and settle counter |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pd_ni | input | 1 | Raw asynchronous power-down request, active low |
| grp_clk_i | input | N_GRP | Source clock of each controlled group |
| stop_ni | input | N_GRP | Raw per-group stop request, active low |
| osc_en_o | output | 1 | Crystal oscillator enable |
| vco_en_o | output | 1 | VCO enable |
| gate_en_o | output | N_GRP | Per-group gate enable, changes only while that clock is low |
| clk_o | output | N_GRP | Gated group clocks |

## Verification
The bound checker checks four ordering properties on every slow-clock cycle. The oscillator and VCO are never off while a gate is open. They never come back with a gate already open. No release happens before the settling count has run out. A synchronised request in the run or settle state always moves the state machine to gate-low or off on the next cycle. The bench scenarios are the only place to see the cross-domain timing: gate closure within three edges of each group's own clock, the stop inputs having no effect during power-down, the restarted settle count after an aborted wake-up, and the widths of the pulses at the gated outputs.

// File: rtl/pwrdn_seq_pkg.sv
package pwrdn_seq_pkg;
  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_GATE_LOW = 2'd1,
    ST_OFF      = 2'd2,
    ST_WAKE     = 2'd3
  } seq_state_e;
endpackage

// File: rtl/pds_sync.sv
module pds_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= {W{RST_VAL}};
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pds_gate.sv
// One clock group: local sync of requests, enable flop on the falling edge.
module pds_gate #(
  parameter int unsigned STAGES = 2
) (
  input  logic grp_clk_i,
  input  logic rst_ni,
  input  logic pd_ni,
  input  logic stop_ni,
  input  logic rel_i,
  output logic en_o,
  output logic clk_o
);
  logic [1:0] req_s;
  logic       rel_s;
  logic       en_q;

  pds_sync #(.W(2), .STAGES(STAGES), .RST_VAL(1'b1)) u_req_sync (
    .clk_i (grp_clk_i),
    .rst_ni(rst_ni),
    .d_i   ({pd_ni, stop_ni}),
    .q_o   (req_s)
  );

  pds_sync #(.W(1), .STAGES(STAGES), .RST_VAL(1'b0)) u_rel_sync (
    .clk_i (grp_clk_i),
    .rst_ni(rst_ni),
    .d_i   (rel_i),
    .q_o   (rel_s)
  );

  // power-down dominates stop; release only granted in run state
  always_ff @(negedge grp_clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= req_s[1] & req_s[0] & rel_s;
  end

  assign en_o  = en_q;
  assign clk_o = grp_clk_i & en_q;
endmodule

// File: rtl/pds_fsm.sv
module pds_fsm
  import pwrdn_seq_pkg::*;
#(
  parameter int unsigned N_GRP         = 3,
  parameter int unsigned SETTLE_CYCLES = 64,
  parameter int unsigned STAGES        = 2
) (
  input  logic             aon_clk_i,
  input  logic             rst_ni,
  input  logic             pd_ni,
  input  logic [N_GRP-1:0] ack_i,
  output logic             osc_en_o,
  output logic             vco_en_o,
  output logic             rel_o
);
  localparam int unsigned CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

  logic             pd_s;
  logic [N_GRP-1:0] ack_s;
  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q;

  pds_sync #(.W(1), .STAGES(STAGES), .RST_VAL(1'b1)) u_pd_sync (
    .clk_i (aon_clk_i),
    .rst_ni(rst_ni),
    .d_i   (pd_ni),
    .q_o   (pd_s)
  );

  pds_sync #(.W(N_GRP), .STAGES(STAGES), .RST_VAL(1'b0)) u_ack_sync (
    .clk_i (aon_clk_i),
    .rst_ni(rst_ni),
    .d_i   (ack_i),
    .q_o   (ack_s)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:      if (!pd_s)          state_d = ST_GATE_LOW;
      ST_GATE_LOW: if (ack_s == '0)    state_d = ST_OFF;
      ST_OFF:      if (pd_s)           state_d = ST_WAKE;
      ST_WAKE: begin
        if (!pd_s)                  state_d = ST_OFF;
        else if (cnt_q == CNT_LAST) state_d = ST_RUN;
      end
      default:                         state_d = ST_OFF;
    endcase
  end

  // reset lands in the settle state so power-on also waits
  always_ff @(posedge aon_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAKE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= (state_q == ST_WAKE && state_d == ST_WAKE) ? cnt_q + 1'b1 : '0;
    end
  end

  assign osc_en_o = (state_q != ST_OFF);
  assign vco_en_o = (state_q != ST_OFF);
  assign rel_o    = (state_q == ST_RUN);
endmodule

// File: rtl/pwrdn_clk_seq.sv
module pwrdn_clk_seq #(
  parameter int unsigned N_GRP         = 3,
  parameter int unsigned SETTLE_CYCLES = 64,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic             aon_clk_i,
  input  logic             rst_ni,
  input  logic             pd_ni,
  input  logic [N_GRP-1:0] grp_clk_i,
  input  logic [N_GRP-1:0] stop_ni,
  output logic             osc_en_o,
  output logic             vco_en_o,
  output logic [N_GRP-1:0] gate_en_o,
  output logic [N_GRP-1:0] clk_o
);
  logic rel;

  pds_fsm #(
    .N_GRP        (N_GRP),
    .SETTLE_CYCLES(SETTLE_CYCLES),
    .STAGES       (SYNC_STAGES)
  ) u_fsm (
    .aon_clk_i(aon_clk_i),
    .rst_ni   (rst_ni),
    .pd_ni    (pd_ni),
    .ack_i    (gate_en_o),
    .osc_en_o (osc_en_o),
    .vco_en_o (vco_en_o),
    .rel_o    (rel)
  );

  for (genvar g = 0; g < int'(N_GRP); g++) begin : g_grp
    pds_gate #(.STAGES(SYNC_STAGES)) u_gate (
      .grp_clk_i(grp_clk_i[g]),
      .rst_ni   (rst_ni),
      .pd_ni    (pd_ni),
      .stop_ni  (stop_ni[g]),
      .rel_i    (rel),
      .en_o     (gate_en_o[g]),
      .clk_o    (clk_o[g])
    );
  end
endmodule

// File: rtl/pwrdn_clk_seq_chk.sv
module pwrdn_clk_seq_chk
  import pwrdn_seq_pkg::*;
#(
  parameter int unsigned N_GRP         = 3,
  parameter int unsigned SETTLE_CYCLES = 64
) (
  input logic             aon_clk_i,
  input logic             rst_ni,
  input logic             osc_en_i,
  input logic             vco_en_i,
  input logic [N_GRP-1:0] gate_en_i,
  input seq_state_e       state_i,
  input logic             pd_s_i,
  input logic             rel_i
);
  localparam int unsigned CNT_W = $clog2(SETTLE_CYCLES + 1);
  logic [CNT_W-1:0] on_cnt_q;

  // cycles with the oscillator up, saturating
  always_ff @(posedge aon_clk_i or negedge rst_ni) begin
    if (!rst_ni)                               on_cnt_q <= '0;
    else if (!osc_en_i)                        on_cnt_q <= '0;
    else if (on_cnt_q != CNT_W'(SETTLE_CYCLES)) on_cnt_q <= on_cnt_q + 1'b1;
  end

  assert_gates_closed_when_off_R3: assert property (@(posedge aon_clk_i) disable iff (!rst_ni)
    (!osc_en_i || !vco_en_i) |-> (gate_en_i == '0));

  assert_wake_with_gates_closed_R5: assert property (@(posedge aon_clk_i) disable iff (!rst_ni)
    $rose(osc_en_i) |-> (gate_en_i == '0));

  assert_settle_before_release_R5: assert property (@(posedge aon_clk_i) disable iff (!rst_ni)
    rel_i |-> (on_cnt_q >= CNT_W'(SETTLE_CYCLES)));

  assert_pd_leaves_run_R2: assert property (@(posedge aon_clk_i) disable iff (!rst_ni)
    (state_i == ST_RUN && !pd_s_i) |=> (state_i == ST_GATE_LOW));

  assert_rewake_abort_R6: assert property (@(posedge aon_clk_i) disable iff (!rst_ni)
    (state_i == ST_WAKE && !pd_s_i) |=> (state_i == ST_OFF && !osc_en_i));
endmodule

bind pwrdn_clk_seq pwrdn_clk_seq_chk #(
  .N_GRP        (N_GRP),
  .SETTLE_CYCLES(SETTLE_CYCLES)
) u_chk (
  .aon_clk_i(aon_clk_i),
  .rst_ni   (rst_ni),
  .osc_en_i (osc_en_o),
  .vco_en_i (vco_en_o),
  .gate_en_i(gate_en_o),
  .state_i  (u_fsm.state_q),
  .pd_s_i   (u_fsm.pd_s),
  .rel_i    (rel)
);

// File: tb/pwrdn_clk_seq_bench.sv
module pwrdn_clk_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_GRP      = 3;
  localparam int SETTLE     = 64;
  localparam int HALF0 = 4, HALF1 = 6, HALF2 = 10;

  logic             aon_clk = 1'b0;
  logic             rst_ni  = 1'b0;
  logic             pd_ni   = 1'b1;
  logic             gclk0 = 1'b0, gclk1 = 1'b0, gclk2 = 1'b0;
  logic [N_GRP-1:0] grp_clk;
  logic [N_GRP-1:0] stop_ni = '1;
  logic             osc_en, vco_en;
  logic [N_GRP-1:0] gate_en, clk_o;

  int checks = 0;
  int failures = 0;

  assign grp_clk = {gclk2, gclk1, gclk0};

  always #(CLK_PERIOD/2) aon_clk = ~aon_clk;
  always #(HALF0) gclk0 = ~gclk0;
  always #(HALF1) gclk1 = ~gclk1;
  always #(HALF2) gclk2 = ~gclk2;

  pwrdn_clk_seq #(.N_GRP(N_GRP), .SETTLE_CYCLES(SETTLE), .SYNC_STAGES(2)) u_pwrdn_clk_seq (
    .aon_clk_i(aon_clk),
    .rst_ni   (rst_ni),
    .pd_ni    (pd_ni),
    .grp_clk_i(grp_clk),
    .stop_ni  (stop_ni),
    .osc_en_o (osc_en),
    .vco_en_o (vco_en),
    .gate_en_o(gate_en),
    .clk_o    (clk_o)
  );

  // R8 pulse-width monitors
  int pulse_err [N_GRP];
  int rises     [N_GRP];
  for (genvar g = 0; g < N_GRP; g++) begin : g_mon
    localparam int HALF = (g == 0) ? HALF0 : (g == 1) ? HALF1 : HALF2;
    longint t_rise = 0, t_fall = 0;
    initial begin pulse_err[g] = 0; rises[g] = 0; end
    always @(posedge clk_o[g]) begin
      if ($time - t_fall < HALF) pulse_err[g]++;
      t_rise = $time;
      rises[g]++;
    end
    always @(negedge clk_o[g]) begin
      if ($time - t_rise != HALF) pulse_err[g]++;
      t_fall = $time;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // next aon rising edge, then sample 2 units later (odd time, clear of group edges)
  task automatic tick(input int n);
    repeat (n) @(posedge aon_clk);
    #2;
  endtask

  task automatic measure_release(input int lo, input int hi, input string tag);
    int n = 0;
    while (gate_en !== '1 && n < 1000) begin tick(1); n++; end
    check(n >= lo && n <= hi, tag, n, lo);
  endtask

  task automatic t_reset;
    tick(3);
    check(osc_en === 1'b1 && vco_en === 1'b1, "R1 enables in reset", {osc_en, vco_en}, 2'b11);
    check(gate_en === '0 && clk_o === '0, "R1 gates in reset", {gate_en, clk_o}, 0);
    #2 rst_ni = 1'b1;
    measure_release(SETTLE, SETTLE + 8, "R1 power-on settle");
  endtask

  task automatic t_stop_run;
    tick(4); #2 stop_ni[1] = 1'b0;
    #36 check(gate_en === 3'b101, "R7 stop closes one group", gate_en, 3'b101);
    stop_ni[1] = 1'b1;
    #36 check(gate_en === 3'b111, "R7 stop release", gate_en, 3'b111);
  endtask

  task automatic t_enter;
    tick(2); #2 pd_ni = 1'b0;
    #24 check(gate_en[0] === 1'b0, "R2 group0 closed", gate_en[0], 0);
    check(osc_en === 1'b1, "R3 osc held during gating", osc_en, 1);
    #12 check(gate_en[1] === 1'b0, "R2 group1 closed", gate_en[1], 0);
    #24 check(gate_en[2] === 1'b0, "R2 group2 closed", gate_en[2], 0);
    tick(8);
    check(osc_en === 1'b0 && vco_en === 1'b0, "R3 enables off", {osc_en, vco_en}, 0);
    check(clk_o === '0, "R3 clocks low when off", clk_o, 0);
  endtask

  task automatic t_stop_ignored;
    bit ok = 1'b1;
    stop_ni = 3'b010;
    tick(2);
    stop_ni = 3'b101;
    for (int i = 0; i < 20; i++) begin
      #3 if (clk_o !== '0 || gate_en !== '0) ok = 1'b0;
    end
    stop_ni = '1;
    for (int i = 0; i < 20; i++) begin
      #3 if (clk_o !== '0 || gate_en !== '0) ok = 1'b0;
    end
    check(ok, "R4 stop ignored in power-down", clk_o, 0);
    tick(1);
    check(osc_en === 1'b0, "R4 still off", osc_en, 0);
  endtask

  task automatic t_exit;
    tick(1); #2 pd_ni = 1'b1;
    tick(4);
    check(osc_en === 1'b1 && vco_en === 1'b1, "R5 enables back", {osc_en, vco_en}, 2'b11);
    check(gate_en === '0, "R5 gates held during settle", gate_en, 0);
    measure_release(SETTLE - 1, SETTLE + 6, "R5 wake settle");
  endtask

  task automatic t_rewake;
    tick(1); #2 pd_ni = 1'b0;
    tick(14);
    check(osc_en === 1'b0, "R6 off before rewake", osc_en, 0);
    #2 pd_ni = 1'b1;
    tick(10);
    check(osc_en === 1'b1 && gate_en === '0, "R6 in settle", {osc_en, gate_en}, 4'b1000);
    #2 pd_ni = 1'b0;
    tick(4);
    check(osc_en === 1'b0 && vco_en === 1'b0 && gate_en === '0, "R6 abort to off",
          {osc_en, vco_en, gate_en}, 0);
    #2 pd_ni = 1'b1;
    tick(4);
    measure_release(SETTLE - 1, SETTLE + 6, "R6 full settle after abort");
  endtask

  task automatic t_pulses;
    tick(4);
    for (int g = 0; g < N_GRP; g++) begin
      check(pulse_err[g] == 0 && rises[g] > 0, "R8 pulse widths", pulse_err[g], 0);
    end
  endtask

  task automatic run_all;
    t_reset();
    t_stop_run();
    t_enter();
    t_stop_ignored();
    t_exit();
    t_rewake();
    t_pulses();
  endtask

  initial begin
    fork
      run_all();
      begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule